// File: doc/BRIEF.md
# Linked-Step I2C Bus Sequencer

This block is an I2C master whose bus waveform is not fixed in logic. The waveform comes from a program memory of step words that the host writes. Each step gives the levels of the clock and data lines, says whether the data line is to be sampled, and holds the address of the step that follows. Within a step word the line levels are inverted: a set bit pulls the line low. The host builds start conditions, bit writes, bit reads, acknowledge bits and stop conditions out of chains of these steps. It loads them through a write port and pulses a go input.

The sequencer then starts at step 0 and applies one step per tick. A tick is a fixed number of system clocks, and it sets the bus bit rate. A step whose next-step field is zero is the last one. Busy falls on the tick that applies it, and the lines keep that step's levels until the next run. Both lines are open-drain: the block only reports when to pull each line low. Data-line samples pass through a synchroniser and are shifted into a read-data word. That word can hold up to four received bytes, and the first byte received is the most significant of them.

Top module: `i2c_step_seq`

## Requirements
- R1: After reset, busy is 0, neither line is pulled low and rd_data is 0.
- R2: A program-port write stores the step at the address in bits [18+ADDR_W-1:18]. From the step it keeps the read-enable (bit 12), the inverted clock level (bit 11), the inverted data level (bit 10) and the next-step address (bits [ADDR_W-1:0]). All other bits of the word have no effect.
- R3: When a step is applied, scl_drive_low takes the value of the step's bit 11 and sda_drive_low takes the value of its bit 10. A 1 pulls the line low and a 0 releases it high.
- R4: A go pulse while idle raises busy on the next clock edge, clears rd_data and starts execution at step 0.
- R5: The first step is applied PRESCALE clock edges after the edge that accepts go, and each further step PRESCALE edges after the one before it.
- R6: Steps are applied in the order of their next-step pointers, not in address order. The step whose next-step field is 0 is the last one, and busy falls on the edge that applies it.
- R7: A go pulse while busy has no effect on the running sequence or its timing.
- R8: When a step with read-enable set is applied, the data line, taken through a two-flop synchroniser, is shifted into bit 0 of rd_data and the older bits move up by one. No other step changes rd_data. After N bytes are read (N from 1 to 4), the first byte received sits in bits [8N-1:8N-8].
- R9: Between steps and after the sequence ends, both line controls keep the levels of the last applied step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_we | input | 1 | Write strobe for the step memory |
| prog_word | input | 32 | Step word: address, read-enable, inverted levels, next pointer |
| go | input | 1 | Starts a run at step 0 when idle |
| sda_in | input | 1 | Level seen on the data line |
| busy | output | 1 | High while a sequence runs |
| scl_drive_low | output | 1 | Pull the clock line low (0 releases it) |
| sda_drive_low | output | 1 | Pull the data line low (0 releases it) |
| rd_data | output | RD_W | Data-line samples collected during the run |

## Verification
The bench builds the block with ADDR_W=8 and PRESCALE=3. The 256-step memory holds a full start, four read bytes with acknowledges and a stop in one program. A three-clock tick gives the two-flop synchroniser time to settle between the slave model's data change and the sample step. It also keeps every step boundary a few cycles apart, so the bench checks the line controls at exact tick positions. Out-of-order pointer chains, a single-step program and a go pulse during a run probe the walk and the end-of-sequence edge.

// File: rtl/i2c_step_seq_pkg.sv
// Package: shared field positions and pin-state type for the step sequencer.
// Assumes a 32-bit step word whose address field fits above bit 18.
package i2c_step_seq_pkg;

    localparam int WORD_W   = 32;
    localparam int POS_ADDR = 18;
    localparam int POS_RD   = 12;
    localparam int POS_NSCL = 11;
    localparam int POS_NSDA = 10;

    // Line controls: a 1 pulls the line low, a 0 releases it.
    typedef struct packed {
        logic scl_low;
        logic sda_low;
    } pins_t;

endpackage

// File: rtl/i2c_step_ram.sv
// Module: step program memory, one synchronous write port and one
// asynchronous read port. It has no reset, so the host must load every
// entry it will run before it pulses go.
module i2c_step_ram #(
    parameter int ADDR_W  = 10,
    parameter int ENTRY_W = 13
) (
    input  logic               clk,
    input  logic               we,
    input  logic [ADDR_W-1:0]  waddr,
    input  logic [ENTRY_W-1:0] wdata,
    input  logic [ADDR_W-1:0]  raddr,
    output logic [ENTRY_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ENTRY_W-1:0] mem [DEPTH];

    // Store a step on a write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the step at the program counter with no added latency.
    assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_step_timer.sv
// Module: tick generator. While busy it raises tick once every PRESCALE
// clocks, the first one PRESCALE-1 edges after busy rises. It is held
// cleared while idle. Assumes PRESCALE >= 2.
module i2c_step_timer #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic tick
);
    localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(PRESCALE - 1);

    logic [CNT_W-1:0] cnt;

    // Count clocks inside a step period, wrapping at the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!busy || cnt == CNT_TOP) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = busy && (cnt == CNT_TOP);

    AST_TICK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> busy); // R5
    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt) < PRESCALE); // R5

endmodule

// File: rtl/i2c_sda_sync.sv
// Module: multi-flop synchroniser for the asynchronous data-line input.
// It resets to 1, the level of a released line. Assumes STAGES >= 2.
module i2c_sda_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw line level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2c_step_core.sv
// Module: sequencer state. It accepts go while idle and walks the pointer
// chain one step per tick. It drives the line controls and shifts samples
// into the read-data word. Assumes tick is only raised while busy.
module i2c_step_core
    import i2c_step_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int RD_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              tick,
    input  logic              step_rd,
    input  logic              step_nscl,
    input  logic              step_nsda,
    input  logic [ADDR_W-1:0] step_next,
    input  logic              sda_s,
    output logic              busy,
    output logic [ADDR_W-1:0] pc,
    output pins_t             pins,
    output logic [RD_W-1:0]   rd_data
);
    logic apply;
    assign apply = busy && tick;

    // Run control: start on go while idle, advance on tick, stop on a zero pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            pc   <= '0;
        end else if (go && !busy) begin
            busy <= 1'b1;
            pc   <= '0;
        end else if (apply) begin
            pc <= step_next;
            if (step_next == '0) begin
                busy <= 1'b0;
            end
        end
    end

    // Line controls: take the levels of each applied step and hold them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins <= '{scl_low: 1'b0, sda_low: 1'b0};
        end else if (apply) begin
            pins <= '{scl_low: step_nscl, sda_low: step_nsda};
        end
    end

    // Read data: clear on start, shift in one sample per read-enabled step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (go && !busy) begin
            rd_data <= '0;
        end else if (apply && step_rd) begin
            rd_data <= {rd_data[RD_W-2:0], sda_s};
        end
    end

    AST_GO_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> (busy && rd_data == '0)); // R4
    AST_GO_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && go && !tick) |=> (busy && $stable(pc))); // R7
    AST_LAST_STEP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick && step_next == '0) |=> !busy); // R6
    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && tick) |=> $stable(pins)); // R9
    AST_RD_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !go) |=> $stable(rd_data)); // R8

endmodule

// File: rtl/i2c_step_seq.sv
// Module: top of the step-programmed I2C master. It splits host step words
// into memory entries and wires the memory, timer, synchroniser and core.
// Assumes an external open-drain pad that pulls each line low when asked.
module i2c_step_seq
    import i2c_step_seq_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int PRESCALE    = 4,
    parameter int RD_W        = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            prog_we,
    input  logic [31:0]     prog_word,
    input  logic            go,
    input  logic            sda_in,
    output logic            busy,
    output logic            scl_drive_low,
    output logic            sda_drive_low,
    output logic [RD_W-1:0] rd_data
);
    localparam int ENTRY_W = 3 + ADDR_W;

    logic [ENTRY_W-1:0] wr_entry;
    logic [ENTRY_W-1:0] rd_entry;
    logic [ADDR_W-1:0]  wr_addr;
    logic [ADDR_W-1:0]  pc;
    logic               tick;
    logic               sda_s;
    pins_t              pins;
    logic               unused_word_bits;

    assign wr_addr  = prog_word[POS_ADDR +: ADDR_W];
    assign wr_entry = {prog_word[POS_RD], prog_word[POS_NSCL],
                       prog_word[POS_NSDA], prog_word[ADDR_W-1:0]};
    assign unused_word_bits = ^prog_word;

    i2c_step_ram #(.ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W)) u_ram (
        .clk   (clk),
        .we    (prog_we),
        .waddr (wr_addr),
        .wdata (wr_entry),
        .raddr (pc),
        .rdata (rd_entry)
    );

    i2c_step_timer #(.PRESCALE(PRESCALE)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .tick  (tick)
    );

    i2c_sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sda_in),
        .dout  (sda_s)
    );

    i2c_step_core #(.ADDR_W(ADDR_W), .RD_W(RD_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .tick      (tick),
        .step_rd   (rd_entry[ENTRY_W-1]),
        .step_nscl (rd_entry[ENTRY_W-2]),
        .step_nsda (rd_entry[ENTRY_W-3]),
        .step_next (rd_entry[ADDR_W-1:0]),
        .sda_s     (sda_s),
        .busy      (busy),
        .pc        (pc),
        .pins      (pins),
        .rd_data   (rd_data)
    );

    assign scl_drive_low = pins.scl_low;
    assign sda_drive_low = pins.sda_low;

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !scl_drive_low && !sda_drive_low)); // R1

endmodule

// File: tb/test_i2c_step_seq.sv
// Scoreboard bench: program builders queue the expected line levels of
// each step, and a monitor compares them at every tick position.
module test_i2c_step_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int PS = 3;
    localparam int RW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_we = 1'b0;
    logic [31:0]   prog_word = '0;
    logic          go = 1'b0;
    logic          sda_in;
    logic          busy;
    logic          scl_drive_low;
    logic          sda_drive_low;
    logic [RW-1:0] rd_data;

    int errors = 0;
    int checks = 0;
    int runs_done = 0;
    logic [2:0] expq[$];          // {last, scl_low, sda_low}
    logic [1:0] last_pins = 2'b00;

    // Program under construction
    logic s_rd [256];
    logic s_sh [256];
    logic s_dh [256];
    int   n_steps = 0;

    // Slave model
    logic stream [1024];
    logic slave_bit = 1'b1;
    logic slave_clr = 1'b0;
    logic prev_scl_low = 1'b0;
    int   fall_idx = 0;

    assign sda_in = sda_drive_low ? 1'b0 : slave_bit;

    i2c_step_seq #(.ADDR_W(AW), .PRESCALE(PS), .RD_W(RW)) i_i2c_step_seq (
        .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_word(prog_word),
        .go(go), .sda_in(sda_in), .busy(busy), .scl_drive_low(scl_drive_low),
        .sda_drive_low(sda_drive_low), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Slave presents the next stream bit after each clock-line fall.
    always @(negedge clk) begin
        if (slave_clr) begin
            fall_idx  <= 0;
            slave_bit <= 1'b1;
        end else if (scl_drive_low && !prev_scl_low) begin
            fall_idx  <= fall_idx + 1;
            slave_bit <= stream[fall_idx + 1];
        end
        prev_scl_low <= scl_drive_low;
    end

    // Monitor: compare line controls at each tick position of a run.
    initial begin
        forever begin
            logic done;
            logic [2:0] e;
            @(posedge busy);
            @(negedge clk);
            chk(rd_data == '0, "R4", "rd_data cleared at start", rd_data, 0);
            done = 1'b0;
            while (!done) begin
                repeat (PS) @(negedge clk);
                if (expq.size() == 0) begin
                    chk(1'b0, "R6", "step beyond program end", 1, 0);
                    done = 1'b1;
                end else begin
                    e = expq.pop_front();
                    chk({scl_drive_low, sda_drive_low} == e[1:0], "R3",
                        "line controls at tick", {scl_drive_low, sda_drive_low}, e[1:0]);
                    chk(busy == !e[2], "R6", "busy versus last step", busy, !e[2]);
                    last_pins = e[1:0];
                    done = e[2];
                end
            end
            runs_done++;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "R6", "watchdog expired", 0, 1);
        summary();
    end

    function automatic logic [31:0] mk(input int addr, input logic rd,
                                       input logic sh, input logic dh, input int nxt);
        logic [31:0] w;
        for (int b = 0; b < 32; b++) begin
            w[b] = (b >= 18 + AW) || (b >= 13 && b <= 17) || (b >= AW && b <= 9);
        end
        w[18 +: AW] = AW'(addr);
        w[12] = rd;
        w[11] = !sh;
        w[10] = !dh;
        w[AW-1:0] = AW'(nxt);
        return w;
    endfunction

    task automatic wr(input logic [31:0] w);
        @(negedge clk);
        prog_we = 1'b1;
        prog_word = w;
        @(negedge clk);
        prog_we = 1'b0;
        prog_word = 32'hFFFF_FFFF;
    endtask

    task automatic add(input logic rd, input logic sh, input logic dh);
        s_rd[n_steps] = rd;
        s_sh[n_steps] = sh;
        s_dh[n_steps] = dh;
        n_steps++;
    endtask

    task automatic p_start(); add(0,1,1); add(0,1,0); add(0,0,0); endtask
    task automatic p_stop();  add(0,0,0); add(0,1,0); add(0,1,1); endtask
    task automatic p_wbit(input logic b); add(0,0,b); add(0,1,b); add(0,0,b); endtask
    task automatic p_rbit(); add(0,0,1); add(0,1,1); add(1,1,1); add(0,0,1); endtask

    task automatic p_wbyte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) p_wbit(v[i]);
        p_wbit(1'b1);
    endtask

    task automatic p_rbyte(input logic last);
        for (int i = 0; i < 8; i++) p_rbit();
        p_wbit(last);
    endtask

    task automatic go_pulse();
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_run(input int prev);
        while (runs_done == prev) @(negedge clk);
    endtask

    // Load the built program in address order and run it.
    task automatic run_linear(input bit mid_go);
        int prev;
        for (int i = 0; i < n_steps; i++) begin
            wr(mk(i, s_rd[i], s_sh[i], s_dh[i], (i == n_steps - 1) ? 0 : i + 1));
            expq.push_back({(i == n_steps - 1) ? 1'b1 : 1'b0, !s_sh[i], !s_dh[i]});
        end
        slave_clr = 1'b1;
        @(negedge clk);
        slave_clr = 1'b0;
        prev = runs_done;
        go_pulse();
        if (mid_go) begin
            repeat (20) @(negedge clk);
            go = 1'b1;
            @(negedge clk);
            go = 1'b0;
        end
        wait_run(prev);
        n_steps = 0;
    endtask

    task automatic read_test(input int nb, input logic [31:0] bytes);
        logic [31:0] exp_v;
        for (int k = 0; k < 1024; k++) stream[k] = 1'b1;
        exp_v = '0;
        for (int b = 0; b < nb; b++) begin
            logic [7:0] v;
            v = bytes[8*(nb-1-b) +: 8];
            for (int j = 0; j < 8; j++) stream[1 + 9*b + j] = v[7-j];
        end
        exp_v = bytes;
        p_start();
        for (int b = 0; b < nb; b++) p_rbyte(b == nb - 1);
        p_stop();
        run_linear(1'b0);
        repeat (4) @(negedge clk);
        chk(rd_data == exp_v, "R8", "read bytes first-most-significant", rd_data, exp_v);
    endtask

    initial begin
        for (int k = 0; k < 1024; k++) stream[k] = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(scl_drive_low == 1'b0, "R1", "clock released after reset", scl_drive_low, 0);
        chk(sda_drive_low == 1'b0, "R1", "data released after reset", sda_drive_low, 0);
        chk(rd_data == '0, "R1", "rd_data after reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R5 R7: write byte with a go pulse in the middle of the run
        p_start();
        p_wbyte(8'hA5);
        p_stop();
        run_linear(1'b1);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0, "R7", "run ends once despite mid-run go", busy, 0);
        chk(rd_data == '0, "R8", "no samples without read-enable", rd_data, 0);

        // R9: levels hold after the end of a run
        repeat (10) @(negedge clk);
        chk({scl_drive_low, sda_drive_low} == last_pins, "R9", "lines hold last step",
            {scl_drive_low, sda_drive_low}, last_pins);

        // R8: one, two and four read bytes
        read_test(1, 32'h0000_005A);
        read_test(2, 32'h0000_C381);
        read_test(4, 32'h1234_5678);

        // R6: pointer chain out of address order 0 -> 5 -> 2 -> 9
        begin
            int prev;
            wr(mk(1, 0, 0, 0, 0));
            wr(mk(0, 0, 1, 1, 5));
            wr(mk(5, 0, 0, 1, 2));
            wr(mk(2, 0, 0, 0, 9));
            wr(mk(9, 0, 1, 1, 0));
            expq.push_back(3'b000);
            expq.push_back(3'b010);
            expq.push_back(3'b011);
            expq.push_back(3'b100);
            prev = runs_done;
            go_pulse();
            wait_run(prev);
        end

        // R5 R6: single-step program, busy lasts exactly PS cycles
        begin
            int prev;
            int hi;
            wr(mk(0, 0, 0, 1, 0));
            expq.push_back(3'b110);
            prev = runs_done;
            hi = 0;
            @(negedge clk);
            go = 1'b1;
            @(negedge clk);
            go = 1'b0;
            while (busy) begin
                hi++;
                @(negedge clk);
            end
            chk(hi == PS, "R5", "busy length of one-step program", hi, PS);
            wait_run(prev);
            repeat (3) @(negedge clk);
            chk({scl_drive_low, sda_drive_low} == 2'b10, "R9", "hold after one-step run",
                {scl_drive_low, sda_drive_low}, 2'b10);
        end

        repeat (5) @(negedge clk);
        chk(expq.size() == 0, "R6", "all queued steps seen", expq.size(), 0);
        summary();
    end

endmodule